// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Bank

This block holds the host-visible registers of two bus-master DMA channels behind a 16-byte I/O window. Channel c owns the 8-byte slot starting at byte 8·c. The low half of each slot holds a command byte and a status byte, with two filler bytes between and after them. The high half holds a 32-bit pointer to the channel's descriptor table. A host bus adapter presents byte, word or dword accesses, and the bank decodes them. Reads are answered combinationally in the same cycle. Writes take effect at the clock edge that samples them.

The command byte carries a start/stop bit and a transfer-direction bit. A 0→1 write of the start bit sends a one-cycle start pulse to that channel's DMA engine and raises the channel's active flag. The direction bit is driven out as a level. The status byte has three kinds of bits: a read-only active bit, two write-one-to-clear event bits (error and interrupt) that hardware sets, and two plain read/write bits. The command and status bytes accept only single-byte accesses. The pointer register accepts accesses of any width.

Top module: `busmaster_regbank`

## Requirements
- R1: Byte-addressed map with aligned accesses. accSize 0 is a byte, 1 is a word, 2 or 3 is a dword. Read data is right-aligned on accRdata, and write data is right-aligned on accWdata. In a slot, offset 0 reads the command byte, offset 2 reads the status byte, offsets 1 and 3 read 0xFF, and offsets 4 to 7 address the pointer.
- R2: A word read at slot offsets 0 to 3 returns 0x0000FFFF. A dword read there returns 0xFFFFFFFF.
- R3: A word or dword write at slot offsets 0 to 3 changes neither the command byte nor the status byte.
- R4: Status bits 5 and 6 take the value of a byte write to status. Bits 3, 4 and 7 always read 0.
- R5: Status bits 1 (error) and 2 (interrupt) are cleared by writing 1 and left as they are by writing 0. Status bit 0 (active) is not changed by a status write.
- R6: A high level on errSet[c] or irqSet[c] sets status bit 1 or bit 2 of channel c at the next edge. The set wins over a clear written in the same cycle.
- R7: The command byte keeps only bit 0 (start) and bit 3 (direction), and its other bits read 0. dirOut[c] follows bit 3.
- R8: A command write that takes bit 0 from 0 to 1 makes startPulse[c] high for exactly the one cycle after the edge and sets status bit 0. Writing 1 while bit 0 is already 1 gives no pulse. Writing 0 clears status bit 0.
- R9: The pointer is written through byte lanes set by the offset and the size. Its two low bits always read 0. descPtr[32c+31:32c] shows channel c's pointer.
- R10: Synchronous reset clears the command, status and pointer of every channel, and clears startPulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| accEn | input | 1 | Access valid this cycle |
| accWr | input | 1 | 1 = write, 0 = read |
| accAddr | input | AW (4) | Byte address within the window |
| accSize | input | 2 | Access width code |
| accWdata | input | 32 | Write data, right-aligned |
| accRdata | output | 32 | Read data, right-aligned, combinational |
| errSet | input | NCH (2) | Per-channel error flag set |
| irqSet | input | NCH (2) | Per-channel interrupt flag set |
| startPulse | output | NCH (2) | One-cycle start request per channel |
| dirOut | output | NCH (2) | Transfer direction per channel |
| descPtr | output | 32·NCH (64) | Descriptor-table pointers, channel 0 in the low word |

## Verification
The bound checker covers, on every cycle, the properties that need only local context. It checks that start pulses last one cycle and coincide with a set active flag. It checks that hardware sets always land, even against a clearing write, and that wide accesses to the command/status bytes read as all ones and leave those registers unchanged. The bench's scenarios are needed for the behaviour that depends on history. That covers the byte-lane merging of the pointer, the forced-low pointer bits, write-one-to-clear against write-zero, the no-pulse rewrite of an already set start bit, and the return of every register to zero after reset.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  // status bit positions
  localparam int unsigned ST_ACT = 0;
  localparam int unsigned ST_ERR = 1;
  localparam int unsigned ST_IRQ = 2;
  localparam int unsigned ST_US5 = 5;
  localparam int unsigned ST_US6 = 6;
  // command bit positions
  localparam int unsigned CMD_GO  = 0;
  localparam int unsigned CMD_DIR = 3;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

  // per-channel strobes from control to datapath
  typedef struct packed {
    logic       cmdWr;
    logic       statWr;
    logic [3:0] ptrBe;
  } chStrobe_t;
endpackage

// File: rtl/bmr_ctrl.sv
module bmr_ctrl
  import bmr_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CW  = 1,
  parameter int AW  = 4
) (
  input  logic                     accEn,
  input  logic                     accWr,
  input  logic [AW-1:0]            accAddr,
  input  logic [1:0]               accSize,
  input  logic [31:0]              accWdata,
  input  logic [NCH-1:0][7:0]      cmdView,
  input  logic [NCH-1:0][7:0]      statView,
  input  logic [NCH-1:0][31:0]     ptrView,
  output chStrobe_t [NCH-1:0]      strobe,
  output logic [31:0]              laneData,
  output logic [31:0]              rdData
);
  logic [CW-1:0] chSel;
  logic [2:0]    slotOff;
  logic          isByte;
  logic          isWord;
  logic [3:0]    laneBe;
  logic [31:0]   ptrShift;

  assign chSel   = accAddr[AW-1:3];
  assign slotOff = accAddr[2:0];
  assign isByte  = (accSize == SZ_BYTE);
  assign isWord  = (accSize == SZ_WORD);

  // replicate write data so every lane sees its own byte
  always_comb begin
    if (isByte)      laneData = {4{accWdata[7:0]}};
    else if (isWord) laneData = {2{accWdata[15:0]}};
    else             laneData = accWdata;
  end

  always_comb begin
    if (isByte)      laneBe = 4'b0001 << slotOff[1:0];
    else if (isWord) laneBe = slotOff[1] ? 4'b1100 : 4'b0011;
    else             laneBe = 4'b1111;
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_strobe
      always_comb begin
        strobe[c] = '0;
        if (accEn && accWr && (chSel == CW'(c))) begin
          if (!slotOff[2]) begin
            strobe[c].cmdWr  = isByte && (slotOff[1:0] == 2'd0);
            strobe[c].statWr = isByte && (slotOff[1:0] == 2'd2);
          end else begin
            strobe[c].ptrBe  = laneBe;
          end
        end
      end
    end
  endgenerate

  always_comb begin
    rdData   = '0;
    ptrShift = '0;
    if (accEn && !accWr && (int'(chSel) < NCH)) begin
      if (!slotOff[2]) begin
        if (isByte) begin
          case (slotOff[1:0])
            2'd0:    rdData = {24'd0, cmdView[chSel]};
            2'd2:    rdData = {24'd0, statView[chSel]};
            default: rdData = 32'h0000_00FF;
          endcase
        end else if (isWord) begin
          rdData = 32'h0000_FFFF;
        end else begin
          rdData = 32'hFFFF_FFFF;
        end
      end else begin
        ptrShift = ptrView[chSel] >> {slotOff[1:0], 3'b000};
        if (isByte)      rdData = {24'd0, ptrShift[7:0]};
        else if (isWord) rdData = {16'd0, ptrShift[15:0]};
        else             rdData = ptrShift;
      end
    end
  end
endmodule

// File: rtl/bmr_datapath.sv
module bmr_datapath
  import bmr_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  chStrobe_t [NCH-1:0]  strobe,
  input  logic [31:0]          laneData,
  input  logic [NCH-1:0]       errSet,
  input  logic [NCH-1:0]       irqSet,
  output logic [NCH-1:0][7:0]  cmdView,
  output logic [NCH-1:0][7:0]  statView,
  output logic [NCH-1:0][31:0] ptrView,
  output logic [NCH-1:0]       startPulse,
  output logic [NCH-1:0]       dirOut
);
  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      logic        goBit, dirBit, actBit, errBit, irqBit, us5Bit, us6Bit, pulseQ;
      logic [31:2] ptrReg;

      always_ff @(posedge clk) begin
        if (rst) begin
          goBit  <= 1'b0;
          dirBit <= 1'b0;
          actBit <= 1'b0;
          errBit <= 1'b0;
          irqBit <= 1'b0;
          us5Bit <= 1'b0;
          us6Bit <= 1'b0;
          pulseQ <= 1'b0;
          ptrReg <= '0;
        end else begin
          pulseQ <= 1'b0;
          if (strobe[ch].cmdWr) begin
            goBit  <= laneData[CMD_GO];
            dirBit <= laneData[CMD_DIR];
            actBit <= laneData[CMD_GO] ? (actBit | ~goBit) : 1'b0;
            pulseQ <= laneData[CMD_GO] & ~goBit;
          end
          errBit <= errSet[ch] | (errBit & ~(strobe[ch].statWr & laneData[ST_ERR]));
          irqBit <= irqSet[ch] | (irqBit & ~(strobe[ch].statWr & laneData[ST_IRQ]));
          if (strobe[ch].statWr) begin
            us5Bit <= laneData[ST_US5];
            us6Bit <= laneData[ST_US6];
          end
          if (strobe[ch].ptrBe[0]) ptrReg[7:2] <= laneData[7:2];
          for (int b = 1; b < 4; b++) begin
            if (strobe[ch].ptrBe[b]) ptrReg[8*b +: 8] <= laneData[8*b +: 8];
          end
        end
      end

      assign cmdView[ch]    = {4'd0, dirBit, 2'd0, goBit};
      assign statView[ch]   = {1'b0, us6Bit, us5Bit, 2'd0, irqBit, errBit, actBit};
      assign ptrView[ch]    = {ptrReg, 2'b00};
      assign startPulse[ch] = pulseQ;
      assign dirOut[ch]     = dirBit;
    end
  endgenerate
endmodule

// File: rtl/busmaster_regbank.sv
module busmaster_regbank
  import bmr_pkg::*;
#(
  parameter  int NCH = 2,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = CW + 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accEn,
  input  logic                accWr,
  input  logic [AW-1:0]       accAddr,
  input  logic [1:0]          accSize,
  input  logic [31:0]         accWdata,
  output logic [31:0]         accRdata,
  input  logic [NCH-1:0]      errSet,
  input  logic [NCH-1:0]      irqSet,
  output logic [NCH-1:0]      startPulse,
  output logic [NCH-1:0]      dirOut,
  output logic [NCH*32-1:0]   descPtr
);
  chStrobe_t [NCH-1:0]  strobe;
  logic [31:0]          laneData;
  logic [NCH-1:0][7:0]  cmdView;
  logic [NCH-1:0][7:0]  statView;
  logic [NCH-1:0][31:0] ptrView;

  bmr_ctrl #(.NCH(NCH), .CW(CW), .AW(AW)) u_ctrl (
    .accEn    (accEn),
    .accWr    (accWr),
    .accAddr  (accAddr),
    .accSize  (accSize),
    .accWdata (accWdata),
    .cmdView  (cmdView),
    .statView (statView),
    .ptrView  (ptrView),
    .strobe   (strobe),
    .laneData (laneData),
    .rdData   (accRdata)
  );

  bmr_datapath #(.NCH(NCH)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .laneData   (laneData),
    .errSet     (errSet),
    .irqSet     (irqSet),
    .cmdView    (cmdView),
    .statView   (statView),
    .ptrView    (ptrView),
    .startPulse (startPulse),
    .dirOut     (dirOut)
  );

  assign descPtr = ptrView;
endmodule

// File: rtl/bmr_chk.sv
module bmr_chk #(
  parameter int NCH = 2,
  parameter int CW  = 1,
  parameter int AW  = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                accEn,
  input logic                accWr,
  input logic [AW-1:0]       accAddr,
  input logic [1:0]          accSize,
  input logic [31:0]         accRdata,
  input logic [NCH-1:0]      errSet,
  input logic [NCH-1:0]      irqSet,
  input logic [NCH-1:0]      startPulse,
  input logic [NCH-1:0][7:0] cmdView,
  input logic [NCH-1:0][7:0] statView
);
  // R2
  wide_rd_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (accEn && !accWr && !accAddr[2] && accSize[1]) |-> (accRdata == 32'hFFFF_FFFF));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (startPulse == '0 && statView == '0 && cmdView == '0));

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
      // R8
      pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        startPulse[ch] |=> !startPulse[ch]);
      // R8
      pulse_active_chk: assert property (@(posedge clk) disable iff (rst)
        startPulse[ch] |-> statView[ch][0]);
      // R6
      err_set_chk: assert property (@(posedge clk) disable iff (rst)
        errSet[ch] |=> statView[ch][1]);
      // R6
      irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        irqSet[ch] |=> statView[ch][2]);
      // R3
      wide_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (accEn && accWr && accSize != 2'd0 && !accAddr[2] &&
         accAddr[AW-1:3] == CW'(ch) && !errSet[ch] && !irqSet[ch])
        |=> ($stable(statView[ch]) && $stable(cmdView[ch])));
    end
  endgenerate
endmodule

bind busmaster_regbank bmr_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .accEn      (accEn),
  .accWr      (accWr),
  .accAddr    (accAddr),
  .accSize    (accSize),
  .accRdata   (accRdata),
  .errSet     (errSet),
  .irqSet     (irqSet),
  .startPulse (startPulse),
  .cmdView    (cmdView),
  .statView   (statView)
);

// File: tb/busmaster_regbank_test.sv
`timescale 1ns/1ps
module busmaster_regbank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        accEn = 1'b0, accWr = 1'b0;
  logic [3:0]  accAddr = '0;
  logic [1:0]  accSize = '0;
  logic [31:0] accWdata = '0;
  logic [31:0] accRdata;
  logic [1:0]  errSet = '0, irqSet = '0;
  logic [1:0]  startPulse, dirOut;
  logic [63:0] descPtr;

  int total = 0;
  int bad = 0;
  logic [31:0] lastRd;

  always #4 clk = ~clk;

  busmaster_regbank uut (
    .clk(clk), .rst(rst), .accEn(accEn), .accWr(accWr), .accAddr(accAddr),
    .accSize(accSize), .accWdata(accWdata), .accRdata(accRdata),
    .errSet(errSet), .irqSet(irqSet), .startPulse(startPulse),
    .dirOut(dirOut), .descPtr(descPtr)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  a;
    logic [1:0]  s;
    logic [31:0] d;   // write data or expected read data
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd0,  2'd0, 32'h0000_0008},  // cmd ch0: direction
    '{1'b0, 4'd0,  2'd0, 32'h0000_0008},  // R7
    '{1'b0, 4'd1,  2'd0, 32'h0000_00FF},  // R1 filler
    '{1'b0, 4'd0,  2'd1, 32'h0000_FFFF},  // R2 word
    '{1'b0, 4'd0,  2'd2, 32'hFFFF_FFFF},  // R2 dword
    '{1'b1, 4'd0,  2'd1, 32'h0000_0000},  // R3 wide write
    '{1'b0, 4'd0,  2'd0, 32'h0000_0008},  // R3 cmd kept
    '{1'b1, 4'd2,  2'd0, 32'h0000_00FF},  // status all ones
    '{1'b0, 4'd2,  2'd0, 32'h0000_0060},  // R4 R5
    '{1'b1, 4'd12, 2'd2, 32'h1234_5677},  // ptr ch1 dword
    '{1'b0, 4'd12, 2'd2, 32'h1234_5674},  // R9 low bits zero
    '{1'b1, 4'd13, 2'd0, 32'h0000_00AB},  // ptr ch1 byte 1
    '{1'b0, 4'd14, 2'd1, 32'h0000_1234},  // R9 upper word
    '{1'b0, 4'd13, 2'd0, 32'h0000_00AB},  // R9 byte 1
    '{1'b1, 4'd14, 2'd1, 32'h0000_BEEF},  // ptr ch1 upper word
    '{1'b0, 4'd12, 2'd2, 32'hBEEF_AB74},  // R9 merge
    '{1'b0, 4'd10, 2'd0, 32'h0000_0000},  // R1 ch1 status
    '{1'b0, 4'd11, 2'd0, 32'h0000_00FF},  // R1 filler
    '{1'b1, 4'd8,  2'd0, 32'h0000_00FE},  // cmd ch1
    '{1'b0, 4'd8,  2'd0, 32'h0000_0008},  // R7 only bits 0/3 kept
    '{1'b0, 4'd4,  2'd2, 32'h0000_0000}   // R1 ch0 ptr untouched
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic acc(input logic wr, input logic [3:0] a, input logic [1:0] s,
                     input logic [31:0] d);
    accEn = 1'b1; accWr = wr; accAddr = a; accSize = s; accWdata = d;
    #1 lastRd = accRdata;
    @(negedge clk);
    accEn = 1'b0; accWr = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R10 reset state
    acc(0, 4'd0, 2'd0, 0);  check("R10 cmd0", lastRd, 0);
    acc(0, 4'd10, 2'd0, 0); check("R10 stat1", lastRd, 0);
    check("R10 pulse", startPulse, 0);
    check("R10 ptr", descPtr, 0);

    for (int i = 0; i < NV; i++) begin
      acc(VECS[i].wr, VECS[i].a, VECS[i].s, VECS[i].wr ? VECS[i].d : 32'd0);
      if (!VECS[i].wr) check($sformatf("R1-vector %0d", i), lastRd, VECS[i].d);
    end
    check("R7 dirOut", dirOut, 2'b11);
    check("R9 descPtr", descPtr, 64'hBEEF_AB74_0000_0000);

    // R10 reset clears nonzero state
    do_reset();
    check("R10 after reset ptr", descPtr, 0);
    check("R10 after reset dir", dirOut, 0);
    acc(0, 4'd2, 2'd0, 0); check("R10 stat0 cleared", lastRd, 0);

    // R8 start sequence
    acc(1, 4'd0, 2'd0, 32'h01);
    check("R8 pulse", startPulse, 2'b01);
    acc(0, 4'd2, 2'd0, 0);
    check("R8 active set", lastRd, 32'h01);
    check("R8 pulse one cycle", startPulse, 2'b00);
    acc(1, 4'd0, 2'd0, 32'h09);
    check("R8 no repeat pulse", startPulse, 2'b00);
    check("R7 dir", dirOut, 2'b01);
    acc(1, 4'd2, 2'd0, 32'h00);
    acc(0, 4'd2, 2'd0, 0); check("R5 active kept", lastRd, 32'h01);
    acc(1, 4'd2, 2'd0, 32'h01);
    acc(0, 4'd2, 2'd0, 0); check("R5 active not written", lastRd, 32'h01);
    acc(1, 4'd0, 2'd0, 32'h00);
    acc(0, 4'd2, 2'd0, 0); check("R8 stop clears active", lastRd, 32'h00);
    acc(1, 4'd8, 2'd0, 32'h01);
    check("R8 ch1 pulse", startPulse, 2'b10);

    // R6 hardware set, R5 write-one-to-clear
    errSet = 2'b01; @(negedge clk); errSet = 2'b00;
    acc(0, 4'd2, 2'd0, 0); check("R6 err set", lastRd, 32'h02);
    acc(1, 4'd2, 2'd0, 32'h04);
    acc(0, 4'd2, 2'd0, 0); check("R5 zero leaves err", lastRd, 32'h02);
    acc(1, 4'd2, 2'd0, 32'h02);
    acc(0, 4'd2, 2'd0, 0); check("R5 clear err", lastRd, 32'h00);
    irqSet = 2'b01;
    acc(1, 4'd2, 2'd0, 32'h04);
    irqSet = 2'b00;
    acc(0, 4'd2, 2'd0, 0); check("R6 set beats clear", lastRd, 32'h04);

    // R3 wide writes to status/cmd ignored
    acc(1, 4'd2, 2'd1, 32'hFFFF);
    acc(0, 4'd2, 2'd0, 0); check("R3 word write status", lastRd, 32'h04);
    acc(1, 4'd0, 2'd2, 32'hFFFF_FFFF);
    acc(0, 4'd0, 2'd0, 0); check("R3 dword write cmd", lastRd, 32'h00);
    check("R3 no pulse", startPulse, 2'b00);

    // R9 pointer out
    acc(1, 4'd4, 2'd2, 32'hCAFE_F00F);
    check("R9 descPtr ch0", descPtr[31:0], 32'hCAFE_F00C);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule